// File: doc/BRIEF.md
# FFT Sample Capture Buffer Controller

This block is the loading stage in front of a 1024/512-point transform engine. Complex samples arrive as an in-phase and a quadrature word with a valid strobe. The block writes each sample into a two-bank sample store. One bank fills while the engine works on the other. The write position comes either from a per-stream sequential counter or from an address supplied with the sample.

The stream layout selects the address map. A single 1024-point transform uses the whole bank. A single 512-point transform uses the lower half. Two concurrent 512-point transforms share the bank: a stream-select input becomes the top address bit. In both 512-point layouts the top bit of an external address is ignored.

A start pulse closes the loading phase. On that edge the block freezes the direction (forward or inverse) and the layout for the engine. It swaps the fill bank, restarts the counters and raises a one-cycle go pulse. The engine reads its bank through a read-address port with one cycle of latency. It reports completion with a done pulse. A synchronous flush input abandons the current load and any handed-over work.

Top module: `fft_in_capture`

## Requirements
- R1: After `rst`, `eng_go` and `eng_busy` are 0 and `eng_bank`, `eng_size` and `eng_inverse` are 0. The first sample loaded in internal mode lands at entry 0 of bank 0.
- R2: With `addr_ext_en`=0 and `cfg_size`=0, the k-th sample accepted since the last start, reset or flush is stored at entry k. Cycles with `in_valid`=0 store nothing and do not advance the position.
- R3: With `addr_ext_en`=1 and `cfg_size`=0 (one 1024-point stream), a valid sample is stored at entry `addr_ext`, using all 10 bits.
- R4: With `cfg_size`=1 (one 512-point stream), samples are stored at entries 0..511 only. Bit 9 of `addr_ext` is ignored, so address 0x3FF stores to entry 511 and 0x205 stores to entry 5.
- R5: With `cfg_size`=2 (two 512-point streams), entry bit 9 equals `in_stream`. Each stream keeps its own sequential position. Bit 9 of `addr_ext` is ignored.
- R6: A `start` sampled high without `flush` gives `eng_go`=1 and `eng_busy`=1 in the next cycle, and `eng_go`=0 in the cycle after. A valid sample in the same cycle as `start` is stored in the bank being handed over.
- R7: On an accepted start, `eng_inverse` takes `cfg_inverse` (1 = inverse transform) and `eng_size` takes `cfg_size`, except that the reserved code 3 is reported as 0. Both hold until the next accepted start.
- R8: Each accepted start hands the current fill bank to the engine: `eng_bank` shows its number. Loading continues in the other bank, with the sequential positions back at 0. `eng_rd_re`/`eng_rd_im` show the entry at `eng_rd_addr` of bank `eng_bank` one cycle after the address is presented.
- R9: `eng_done` clears `eng_busy` in the next cycle.
- R10: `flush` clears `eng_busy` and `eng_go`, returns the fill bank and `eng_bank` to 0, and resets the sequential positions. A `start` in the same cycle as `flush` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of load and hand-over state |
| cfg_inverse | input | 1 | 0 forward, 1 inverse transform |
| cfg_size | input | 2 | 0 one 1024-pt, 1 one 512-pt, 2 two 512-pt, 3 reserved |
| in_valid | input | 1 | Sample strobe |
| in_re | input | DW | In-phase sample |
| in_im | input | DW | Quadrature sample |
| in_stream | input | 1 | Stream select in the two-stream layout |
| addr_ext_en | input | 1 | 1 uses addr_ext as the write position |
| addr_ext | input | AW | External write position |
| start | input | 1 | Close loading and hand the bank over |
| eng_rd_addr | input | AW | Engine read position in its bank |
| eng_done | input | 1 | Engine completion pulse |
| eng_go | output | 1 | One-cycle launch pulse |
| eng_busy | output | 1 | Engine holds a bank |
| eng_bank | output | 1 | Bank number handed to the engine |
| eng_inverse | output | 1 | Latched direction |
| eng_size | output | 2 | Latched layout, reserved code mapped to 0 |
| eng_rd_re | output | DW | Registered in-phase read data |
| eng_rd_im | output | DW | Registered quadrature read data |

## Verification
The properties assume two things about the environment. `start` is never raised while `eng_busy` is high, and `eng_done` only pulses while `eng_busy` is high. The go pulse and the bank alternation are stated only under this hand-over discipline. The bench's engine stub arms its fixed-latency done pulse from `eng_go` and disarms whenever `eng_busy` is low. The bench waits for each done before loading the next start, and uses `flush` rather than a second start to abandon work.

// File: rtl/fft_cap_pkg.sv
package fft_cap_pkg;
  typedef enum logic [1:0] {
    SZ_FULL = 2'd0,
    SZ_HALF = 2'd1,
    SZ_DUAL = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  function automatic logic [1:0] norm_size(input logic [1:0] s);
    return (size_e'(s) == SZ_RSVD) ? 2'(SZ_FULL) : s;
  endfunction
endpackage

// File: rtl/fft_cap_addr_gen.sv
module fft_cap_addr_gen #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          restart,
  input  logic          in_valid,
  input  logic          in_stream,
  input  logic          ext_en,
  input  logic [AW-1:0] ext_addr,
  input  logic [1:0]    size,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);
  import fft_cap_pkg::*;
  localparam int HW = AW - 1;
  localparam int NSTREAM = 2;

  logic [NSTREAM-1:0][AW-1:0] pos;
  logic                       sel;
  logic [AW-1:0]              base;

  assign wr_en = in_valid & ~flush;
  assign sel   = (size_e'(size) == SZ_DUAL) & in_stream;

  for (genvar g = 0; g < NSTREAM; g++) begin : g_pos
    logic [AW-1:0] c;
    always_ff @(posedge clk) begin
      if (rst || flush || restart)
        c <= '0;
      else if (wr_en && !ext_en && (sel == 1'(g)))
        c <= c + 1'b1;
    end
    assign pos[g] = c;
  end

  assign base = ext_en ? ext_addr : pos[sel];

  always_comb begin
    case (size_e'(size))
      SZ_HALF: wr_addr = {1'b0, base[HW-1:0]};
      SZ_DUAL: wr_addr = {in_stream, base[HW-1:0]};
      default: wr_addr = base;
    endcase
  end
endmodule

// File: rtl/fft_cap_bank_ram.sv
module fft_cap_bank_ram #(
  parameter int DW = 24,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fft_cap_ctrl.sv
module fft_cap_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       start,
  input  logic       eng_done,
  input  logic       cfg_inverse,
  input  logic [1:0] cfg_size,
  output logic       accept,
  output logic       wr_bank,
  output logic       eng_bank,
  output logic       eng_go,
  output logic       eng_busy,
  output logic       eng_inverse,
  output logic [1:0] eng_size
);
  import fft_cap_pkg::*;

  assign accept = start & ~flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_bank  <= 1'b0;
      eng_bank <= 1'b0;
      eng_go   <= 1'b0;
      eng_busy <= 1'b0;
    end else begin
      eng_go <= accept;
      if (accept) begin
        wr_bank  <= ~wr_bank;
        eng_bank <= wr_bank;
        eng_busy <= 1'b1;
      end else if (eng_done) begin
        eng_busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_inverse <= 1'b0;
      eng_size    <= 2'd0;
    end else if (accept) begin
      eng_inverse <= cfg_inverse;
      eng_size    <= norm_size(cfg_size);
    end
  end
endmodule

// File: rtl/fft_in_capture.sv
module fft_in_capture #(
  parameter int DW = 12,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          cfg_inverse,
  input  logic [1:0]    cfg_size,
  input  logic          in_valid,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic          in_stream,
  input  logic          addr_ext_en,
  input  logic [AW-1:0] addr_ext,
  input  logic          start,
  input  logic [AW-1:0] eng_rd_addr,
  input  logic          eng_done,
  output logic          eng_go,
  output logic          eng_busy,
  output logic          eng_bank,
  output logic          eng_inverse,
  output logic [1:0]    eng_size,
  output logic [DW-1:0] eng_rd_re,
  output logic [DW-1:0] eng_rd_im
);
  localparam int SW = 2 * DW;
  localparam int RAW = AW + 1;

  logic          accept;
  logic          wr_bank;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] rd_word;

  fft_cap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .start(start), .eng_done(eng_done),
    .cfg_inverse(cfg_inverse), .cfg_size(cfg_size), .accept(accept),
    .wr_bank(wr_bank), .eng_bank(eng_bank), .eng_go(eng_go),
    .eng_busy(eng_busy), .eng_inverse(eng_inverse), .eng_size(eng_size)
  );

  fft_cap_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .flush(flush), .restart(accept),
    .in_valid(in_valid), .in_stream(in_stream), .ext_en(addr_ext_en),
    .ext_addr(addr_ext), .size(cfg_size), .wr_en(wr_en), .wr_addr(wr_addr)
  );

  fft_cap_bank_ram #(.DW(SW), .AW(RAW)) u_ram (
    .clk(clk), .we(wr_en), .waddr({wr_bank, wr_addr}), .wdata({in_re, in_im}),
    .raddr({eng_bank, eng_rd_addr}), .rdata(rd_word)
  );

  assign eng_rd_re = rd_word[SW-1:DW];
  assign eng_rd_im = rd_word[DW-1:0];
endmodule

// File: rtl/fft_in_capture_chk.sv
module fft_in_capture_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          start,
  input logic          in_stream,
  input logic [1:0]    cfg_size,
  input logic          eng_done,
  input logic          eng_go,
  input logic          eng_busy,
  input logic          eng_bank,
  input logic          eng_inverse,
  input logic [1:0]    eng_size,
  input logic          wr_bank,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);
  // Environment discipline for R6 and R9
  p_start_idle_r6: assert property (@(posedge clk) disable iff (rst)
    start |-> !eng_busy);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (rst)
    eng_done |-> eng_busy);

  p_go_next_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !flush) |=> (eng_go && eng_busy));
  p_go_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    eng_go |=> !eng_go);
  p_bank_swap_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !flush) |=> (eng_bank == $past(wr_bank)) && (wr_bank != $past(wr_bank)));
  p_size_legal_r7: assert property (@(posedge clk) disable iff (rst)
    eng_size != 2'd3);
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !eng_go |-> ($stable(eng_size) && $stable(eng_inverse)));
  p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> !eng_busy);
  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!eng_busy && !eng_go && !eng_bank && !wr_bank));
  p_half_low_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cfg_size == 2'd1) |-> !wr_addr[AW-1]);
  p_stream_msb_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cfg_size == 2'd2) |-> (wr_addr[AW-1] == in_stream));
endmodule

bind fft_in_capture fft_in_capture_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .start(start), .in_stream(in_stream),
  .cfg_size(cfg_size), .eng_done(eng_done), .eng_go(eng_go),
  .eng_busy(eng_busy), .eng_bank(eng_bank), .eng_inverse(eng_inverse),
  .eng_size(eng_size), .wr_bank(wr_bank), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/tb_fft_in_capture.sv
`timescale 1ns/1ps
module tb_fft_in_capture;
  localparam int DW = 12;
  localparam int AW = 10;
  localparam int LAT = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, flush = 1'b0, cfg_inverse = 1'b0, in_valid = 1'b0;
  logic [1:0] cfg_size = 2'd0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic in_stream = 1'b0, addr_ext_en = 1'b0, start = 1'b0, eng_done = 1'b0;
  logic [AW-1:0] addr_ext = '0, eng_rd_addr = '0;
  logic eng_go, eng_busy, eng_bank, eng_inverse;
  logic [1:0] eng_size;
  logic [DW-1:0] eng_rd_re, eng_rd_im;

  fft_in_capture #(.DW(DW), .AW(AW)) dut (.*);

  int n_chk = 0, n_fail = 0, dcount = 0, stub_cnt = 0;
  bit tb_bank = 1'b0, rd_req = 1'b0, req_q = 1'b0;
  logic [2*DW-1:0] expm [2][1 << AW];

  typedef struct { logic [2*DW-1:0] d; string tag; int idx; } rd_t;
  rd_t q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // engine stub: fixed-latency done pulse, disarmed when not busy
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (eng_go) stub_cnt = LAT;
    else if (!eng_busy) stub_cnt = 0;
    else if (stub_cnt > 0) begin
      stub_cnt--;
      if (stub_cnt == 0) eng_done = 1'b1;
    end
  end

  // scoreboard monitor
  always @(posedge clk) req_q <= rd_req;
  always @(negedge clk) begin
    if (req_q) begin
      rd_t it;
      if (q.size() == 0) chk(1'b0, "scoreboard", "empty queue", 0, 1);
      else begin
        it = q.pop_front();
        chk({eng_rd_re, eng_rd_im} === it.d, it.tag, $sformatf("entry %0d", it.idx),
            {eng_rd_re, eng_rd_im}, it.d);
      end
    end
  end

  task automatic put(input int idx, input logic s, input logic e, input int a,
                     input logic st);
    logic [2*DW-1:0] w;
    @(negedge clk);
    w = {DW'(12'h0A0 + dcount * 3), DW'(12'h500 ^ dcount)};
    dcount++;
    in_valid = 1'b1; {in_re, in_im} = w; in_stream = s;
    addr_ext_en = e; addr_ext = AW'(a); start = st;
    expm[tb_bank][idx] = w;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; start = 1'b0; flush = 1'b0;
      in_re = DW'(12'hBAD); in_im = DW'(12'hBAD); addr_ext = AW'(dcount);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    in_valid = 1'b0; start = 1'b1;
  endtask

  task automatic after_start(input bit b, input int sz, input bit inv, input string tag);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    chk(eng_go === 1'b1, "R6", "go after start", eng_go, 1);
    chk(eng_busy === 1'b1, "R6", "busy after start", eng_busy, 1);
    chk(eng_bank === b, "R8", "handed bank", eng_bank, b);
    chk(eng_size === 2'(sz), tag, "latched size", eng_size, sz);
    chk(eng_inverse === inv, "R7", "latched direction", eng_inverse, inv);
    tb_bank = ~tb_bank;
    @(negedge clk);
    chk(eng_go === 1'b0, "R6", "go is one cycle", eng_go, 0);
  endtask

  task automatic rd(input bit b, input int idx, input string tag);
    rd_t it;
    @(negedge clk);
    eng_rd_addr = AW'(idx); rd_req = 1'b1;
    it.d = expm[b][idx]; it.tag = tag; it.idx = idx;
    q.push_back(it);
  endtask

  task automatic rd_end();
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done();
    @(posedge clk iff eng_done);
    @(negedge clk);
    chk(eng_busy === 1'b0, "R9", "busy after done", eng_busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(eng_go === 1'b0, "R1", "go after reset", eng_go, 0);
    chk(eng_busy === 1'b0, "R1", "busy after reset", eng_busy, 0);
    chk(eng_bank === 1'b0, "R1", "bank after reset", eng_bank, 0);
    chk(eng_size === 2'd0, "R1", "size after reset", eng_size, 0);

    // A: internal, full size, gaps, last sample carries start (bank 0)
    cfg_size = 2'd0; cfg_inverse = 1'b1;
    put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0); idle(2);
    put(2, 0, 0, 0, 0); idle(1); put(3, 0, 0, 0, 0); put(4, 0, 0, 0, 0);
    put(5, 0, 0, 0, 1);
    after_start(1'b0, 0, 1'b1, "R7");
    rd(0, 0, "R1"); rd(0, 1, "R2"); rd(0, 2, "R2"); rd(0, 3, "R2");
    rd(0, 4, "R2"); rd(0, 5, "R6"); rd_end();
    wait_done();

    // B: external, full size (bank 1)
    cfg_inverse = 1'b0;
    put(1023, 0, 1, 1023, 0); put(512, 0, 1, 512, 0); idle(1);
    put(7, 0, 1, 7, 0); put(300, 0, 1, 300, 0); idle(3);
    pulse_start();
    after_start(1'b1, 0, 1'b0, "R7");
    rd(1, 1023, "R3"); rd(1, 512, "R3"); rd(1, 7, "R3"); rd(1, 300, "R3");
    rd_end();
    wait_done();

    // C: single 512 (bank 0)
    cfg_size = 2'd1;
    put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0); put(2, 0, 0, 0, 0);
    put(511, 0, 1, 'h3FF, 0); put(5, 0, 1, 'h205, 0); idle(1);
    pulse_start();
    after_start(1'b0, 1, 1'b0, "R7");
    rd(0, 0, "R8"); rd(0, 1, "R8"); rd(0, 2, "R8");
    rd(0, 511, "R4"); rd(0, 5, "R4"); rd_end();
    wait_done();

    // D: two 512 streams (bank 1), start on last sample
    cfg_size = 2'd2; cfg_inverse = 1'b1;
    put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0); put(512, 1, 0, 0, 0);
    put(2, 0, 0, 0, 0); put(513, 1, 0, 0, 0);
    put(517, 1, 1, 'h005, 0); put(8, 0, 1, 'h208, 1);
    after_start(1'b1, 2, 1'b1, "R7");
    rd(1, 0, "R5"); rd(1, 1, "R5"); rd(1, 512, "R5"); rd(1, 2, "R5");
    rd(1, 513, "R5"); rd(1, 517, "R5"); rd(1, 8, "R5"); rd_end();
    wait_done();

    // E: reserved size code (bank 0), config held after start
    cfg_size = 2'd3; cfg_inverse = 1'b0;
    put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 1);
    after_start(1'b0, 0, 1'b0, "R7");
    cfg_size = 2'd2; cfg_inverse = 1'b1;
    idle(2);
    chk(eng_size === 2'd0, "R7", "size held", eng_size, 0);
    chk(eng_inverse === 1'b0, "R7", "direction held", eng_inverse, 0);
    rd(0, 0, "R7"); rd(0, 1, "R7"); rd_end();
    wait_done();

    // F: flush behaviour
    cfg_size = 2'd0; cfg_inverse = 1'b0;
    put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0); put(2, 0, 0, 0, 0);
    @(negedge clk); in_valid = 1'b0; flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    tb_bank = 1'b0;
    put(0, 0, 0, 0, 0); put(1, 0, 0, 0, 0);
    @(negedge clk); in_valid = 1'b0; start = 1'b1; flush = 1'b1;
    @(negedge clk); start = 1'b0; flush = 1'b0;
    chk(eng_go === 1'b0, "R10", "start masked by flush", eng_go, 0);
    chk(eng_busy === 1'b0, "R10", "busy masked by flush", eng_busy, 0);
    pulse_start();
    after_start(1'b0, 0, 1'b0, "R7");
    rd(0, 0, "R10"); rd(0, 1, "R10"); rd_end();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk(eng_busy === 1'b0, "R10", "busy cleared by flush", eng_busy, 0);
    chk(eng_bank === 1'b0, "R10", "bank cleared by flush", eng_bank, 0);
    idle(3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule